// File: doc/BRIEF.md
# Prescaled Overflow Timer

This block is an up-counter that advances at the instruction-cycle rate, which is the core clock divided by a fixed factor (four by default). A power-of-two prescaler sits between that rate and the counter, so the counter steps once every 2, 4, ... 256 instruction cycles. A bypass bit removes the prescaler, and the counter then steps once per instruction cycle. When the counter rolls over from its all-ones value to zero, it sets a sticky overflow flag. This happens whether or not the interrupt is enabled. The flag reaches the interrupt output only when both a timer enable and a global enable are set.

Software reaches the block through a small register port. Writes are one cycle wide and take effect at the next clock edge. Reads are combinational from a separate read address. Three registers are mapped: the count, the option register (ratio select and bypass) and the control register (flag and the two enables). Writing the count reloads it and restarts the prescaler, so the next step comes one full prescale period after the write. Software clears the flag by writing the control register with bit 0 low.

Top module: `ovf_timer`

## Requirements
- R1: After a synchronous active-low reset, the count, option and control registers all read 0 and `irq` is 0. Option 0 selects a ratio of 2 with the bypass off.
- R2: With the bypass bit (option bit 3) set, the count steps exactly once every `CYC_DIV` clock cycles (4 by default).
- R3: With the bypass clear, option bits [2:0] = s make the count step exactly once every 2^(s+1) instruction cycles, from a ratio of 2 (s = 0) to a ratio of 256 (s = 7).
- R4: When the count steps from 255 to 0, the overflow flag (control bit 0) becomes 1 in the same clock edge. This does not depend on either enable bit.
- R5: A write to address 0 loads the count at the next edge. It has priority over a step in that cycle, and it clears the prescaler's accumulated instruction cycles.
- R6: The overflow flag stays set until a control write with bit 0 = 0. An overflow in the same cycle as that write leaves the flag at 1.
- R7: `irq` equals the flag ANDed with the timer enable (control bit 1) and the global enable (control bit 2).
- R8: The address map is: 0 for the count, 1 for the option register (bits [2:0] ratio select, bit 3 bypass, upper bits read 0), 2 for the control register (bit 0 flag, bit 1 timer enable, bit 2 global enable, upper bits read 0). Address 3 reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register write address |
| wr_data | input | CNT_W (8) | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | CNT_W (8) | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit ratio select and a divide-by-four instruction cycle. At these values every ratio can be reached within the run, up to one step per 1024 clocks at ratio 256. The bench preloads the count to 255 so that a rollover at the slowest ratio arrives after a single step rather than after 256 of them. Random writes, weighted toward count values near 255, make overflows collide with flag clears and with count reloads. The exact step interval at each ratio is measured at the read port.

// File: rtl/ovf_timer_pkg.sv
// Shared constants of the prescaled overflow timer: register addresses
// and control-register bit positions. Assumes a 2-bit register address.
package ovf_timer_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
    localparam logic [ADDR_W-1:0] A_OPTION = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    localparam int CTRL_FLAG = 0;
    localparam int CTRL_TIE  = 1;
    localparam int CTRL_GIE  = 2;
endpackage

// File: rtl/tmr_cycle_div.sv
// Instruction-cycle divider: produces a one-clock tick every DIV clocks.
// Assumes DIV >= 2. Runs freely from reset and is never cleared by software.
module tmr_cycle_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cyc_q;

    // Phase counter: wraps at DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n)             cyc_q <= '0;
        else if (cyc_q == LAST) cyc_q <= '0;
        else                    cyc_q <= cyc_q + 1'b1;
    end

    assign tick = (cyc_q == LAST);
endmodule

// File: rtl/tmr_prescale.sv
// Power-of-two prescaler: counts instruction ticks and emits a step every
// 2^(sel+1) ticks, or on every tick when bypassed. Assumes the ratio never
// exceeds 2^PRE_W, so the accumulator wraps on a step boundary.
module tmr_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic             bypass,
    input  logic [SEL_W-1:0] sel,
    output logic             step
);
    localparam int PRE_W = 1 << SEL_W;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] mask;
    logic             full;

    // Ratio mask: the low (sel+1) bits of the accumulator.
    always_comb begin
        span = (PRE_W+1)'(2) << sel;
        mask = PRE_W'(span - (PRE_W+1)'(1));
        full = &(pre_q | ~mask);
    end

    // Accumulator: cleared on count reload, advanced on ticks when active.
    always_ff @(posedge clk) begin
        if (!rst_n)               pre_q <= '0;
        else if (clr)             pre_q <= '0;
        else if (tick && !bypass) pre_q <= pre_q + 1'b1;
    end

    assign step = tick && (bypass || full);
endmodule

// File: rtl/tmr_core.sv
// Count register and sticky overflow flag. A reload beats a step; an
// overflow beats a software write of the flag.
module tmr_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_wr,
    input  logic             flag_wdat,
    output logic [CNT_W-1:0] cnt,
    output logic             flag
);
    logic ovf;

    assign ovf = step && !cnt_wr && (cnt == {CNT_W{1'b1}});

    // Count: reload has priority, otherwise step by one.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= wr_data;
        else if (step)   cnt <= cnt + 1'b1;
    end

    // Sticky flag: set on overflow, else software may load it.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (ovf)     flag <= 1'b1;
        else if (flag_wr) flag <= flag_wdat;
    end
endmodule

// File: rtl/tmr_regfile.sv
// Register decode: option and enable registers, write strobes toward the
// core, and the combinational read mux. Assumes CNT_W >= SEL_W + 1 and >= 3.
module tmr_regfile
    import ovf_timer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEL_W:0]    wr_low,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              flag,
    output logic              cnt_wr,
    output logic              flag_wr,
    output logic              flag_wdat,
    output logic [SEL_W-1:0]  sel,
    output logic              bypass,
    output logic              tie,
    output logic              gie,
    output logic [CNT_W-1:0]  rd_data
);
    logic opt_wr;

    assign cnt_wr    = wr_en && (wr_addr == A_COUNT);
    assign opt_wr    = wr_en && (wr_addr == A_OPTION);
    assign flag_wr   = wr_en && (wr_addr == A_CTRL);
    assign flag_wdat = wr_low[CTRL_FLAG];

    // Option register: ratio select and bypass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= '0;
            bypass <= 1'b0;
        end else if (opt_wr) begin
            sel    <= wr_low[SEL_W-1:0];
            bypass <= wr_low[SEL_W];
        end
    end

    // Enable bits of the control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tie <= 1'b0;
            gie <= 1'b0;
        end else if (flag_wr) begin
            tie <= wr_low[CTRL_TIE];
            gie <= wr_low[CTRL_GIE];
        end
    end

    // Read mux, zero-extending the narrow registers.
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_COUNT:  rd_data = cnt;
            A_OPTION: rd_data = CNT_W'({bypass, sel});
            A_CTRL:   rd_data = CNT_W'({gie, tie, flag});
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ovf_timer.sv
// Prescaled overflow timer top: clock divider, prescaler, count core and
// register decode. The interrupt output is the flag gated by both enables.
module ovf_timer
    import ovf_timer_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int SEL_W   = 3,
    parameter int CYC_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    logic             inst_tick;
    logic             step;
    logic             cnt_wr;
    logic             flag_wr;
    logic             flag_wdat;
    logic [SEL_W-1:0] sel;
    logic             bypass;
    logic             tie;
    logic             gie;
    logic [CNT_W-1:0] cnt;
    logic             flag;

    tmr_cycle_div #(.DIV(CYC_DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (inst_tick)
    );

    tmr_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (inst_tick),
        .clr   (cnt_wr),
        .bypass(bypass),
        .sel   (sel),
        .step  (step)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .cnt_wr   (cnt_wr),
        .wr_data  (wr_data),
        .flag_wr  (flag_wr),
        .flag_wdat(flag_wdat),
        .cnt      (cnt),
        .flag     (flag)
    );

    tmr_regfile #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_low   (wr_data[SEL_W:0]),
        .rd_addr  (rd_addr),
        .cnt      (cnt),
        .flag     (flag),
        .cnt_wr   (cnt_wr),
        .flag_wr  (flag_wr),
        .flag_wdat(flag_wdat),
        .sel      (sel),
        .bypass   (bypass),
        .tie      (tie),
        .gie      (gie),
        .rd_data  (rd_data)
    );

    assign irq = flag && tie && gie;
endmodule

// File: rtl/ovf_timer_checker.sv
// Temporal checks on the timer, attached to every ovf_timer instance by bind.
module ovf_timer_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             step,
    input logic             cnt_wr,
    input logic             flag_wr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt,
    input logic             flag,
    input logic             irq
);
    assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> tick);

    assert_hold_without_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !cnt_wr) |=> $stable(cnt));

    assert_wrap_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !cnt_wr && cnt == {CNT_W{1'b1}}) |=> (flag && cnt == '0));

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wr_data)));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_wr) |=> flag);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);
endmodule

bind ovf_timer ovf_timer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (inst_tick),
    .step   (step),
    .cnt_wr (cnt_wr),
    .flag_wr(flag_wr),
    .wr_data(wr_data),
    .cnt    (cnt),
    .flag   (flag),
    .irq    (irq)
);

// File: tb/test_ovf_timer.sv
`timescale 1ns/1ps
module test_ovf_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ovf_timer i_ovf_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    // Reference model state, advanced at each rising edge from the requirements.
    int       m_cyc, m_pre;
    logic [7:0] m_cnt;
    logic [2:0] m_sel;
    logic     m_byp, m_flag, m_tie, m_gie;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cyc = 0; m_pre = 0; m_cnt = 0; m_sel = 0;
            m_byp = 0; m_flag = 0; m_tie = 0; m_gie = 0;
        end else begin
            bit tk, st, ov;
            int ratio;
            ratio = 2 << m_sel;
            tk = (m_cyc == 3);
            st = tk && (m_byp || (m_pre % ratio) == ratio - 1);
            ov = st && m_cnt == 8'hFF && !(wr_en && wr_addr == 2'd0);
            m_cyc = (m_cyc + 1) % 4;
            if (wr_en && wr_addr == 2'd0) begin
                m_cnt = wr_data; m_pre = 0;
            end else begin
                if (st) m_cnt = m_cnt + 8'd1;
                if (tk && !m_byp) m_pre = (m_pre + 1) & 255;
            end
            if (wr_en && wr_addr == 2'd1) begin
                m_sel = wr_data[2:0]; m_byp = wr_data[3];
            end
            if (ov) m_flag = 1'b1;
            else if (wr_en && wr_addr == 2'd2) m_flag = wr_data[0];
            if (wr_en && wr_addr == 2'd2) begin
                m_tie = wr_data[1]; m_gie = wr_data[2];
            end
        end
    end

    function automatic logic [7:0] model_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_cnt;
            2'd1:    return {4'b0, m_byp, m_sel};
            2'd2:    return {5'b0, m_gie, m_tie, m_flag};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, got, exp, $time);
        end
    endtask

    // Read a register at the current negedge and compare with the model.
    task automatic chk_reg(input logic [1:0] a, input string req);
        rd_addr = a;
        #1;
        check(req, rd_data, model_read(a));
    endtask

    task automatic chk_val(input logic [1:0] a, input int exp, input string req);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clocks between two successive count steps.
    task automatic measure(input int exp, input string req);
        logic [7:0] last;
        int gap;
        @(negedge clk); rd_addr = 2'd0; #1; last = rd_data;
        while (rd_data == last) begin @(negedge clk); #1; end
        last = rd_data; gap = 0;
        while (rd_data == last && gap < 5000) begin @(negedge clk); #1; gap++; end
        check(req, gap, exp);
    endtask

    initial begin
        void'($urandom(32'd20240917));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_val(2'd0, 0, "R1 count");
        chk_val(2'd1, 0, "R1 option");
        chk_val(2'd2, 0, "R1 control");
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R1 irq actual=%0b expected=0", irq); end

        // R2: bypass, one step per instruction cycle
        wr(2'd1, 8'h08);
        measure(4, "R2 bypass interval");
        // R3: every ratio
        for (int s = 0; s < 8; s++) begin
            wr(2'd1, 8'(s));
            measure(4 * (2 << s), "R3 prescale interval");
        end
        // R5: reload restarts the prescaler (ratio 8 -> 32 clocks)
        wr(2'd1, 8'h02);
        idle(13);
        wr(2'd0, 8'h40);
        @(negedge clk); chk_val(2'd0, 8'h40, "R5 reload value");
        chk_reg(2'd0, "R5 reload vs model");
        idle(20);
        chk_val(2'd0, 8'h40, "R5 no early step after reload");
        idle(20);
        chk_reg(2'd0, "R5 step after full period");

        // R4: wrap at ratio 256 with enables off
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h07);
        wr(2'd0, 8'hFF);
        idle(1100);
        chk_val(2'd0, 0, "R4 wrapped count");
        chk_val(2'd2, 1, "R4 flag set with enables off");
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R7 irq actual=%0b expected=0", irq); end
        // R6: sticky
        idle(30);
        chk_val(2'd2, 1, "R6 flag sticky");
        // R7: gating
        wr(2'd2, 8'h03); @(negedge clk); #1;
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R7 tie only actual=%0b expected=0", irq); end
        wr(2'd2, 8'h05); @(negedge clk); #1;
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R7 gie only actual=%0b expected=0", irq); end
        wr(2'd2, 8'h07); @(negedge clk); #1;
        checks++; if (irq !== 1'b1) begin errors++; $display("FAIL R7 both actual=%0b expected=1", irq); end
        // R6: clear
        wr(2'd2, 8'h06);
        chk_val(2'd2, 6, "R6 flag cleared");
        checks++; if (irq !== 1'b0) begin errors++; $display("FAIL R7 after clear actual=%0b expected=0", irq); end

        // R8: map and address 3
        wr(2'd1, 8'hFF);
        chk_val(2'd1, 8'h0F, "R8 option upper bits zero");
        wr(2'd3, 8'hA5);
        chk_val(2'd3, 0, "R8 address 3 reads zero");
        chk_reg(2'd0, "R8 address 3 write ignored count");
        chk_reg(2'd1, "R8 address 3 write ignored option");
        chk_reg(2'd2, "R8 address 3 write ignored control");

        // Random phase with collisions near rollover
        wr(2'd1, 8'h08);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if ($urandom_range(0, 5) == 0) begin
                wr_en = 1'b1;
                wr_addr = 2'($urandom_range(0, 3));
                if (wr_addr == 2'd0) wr_data = 8'($urandom_range(250, 255));
                else if (wr_addr == 2'd1) wr_data = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h08;
                else wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            rd_addr = 2'($urandom_range(0, 3));
            #1;
            case (rd_addr)
                2'd0:    check("R3 random count", rd_data, model_read(rd_addr));
                2'd2:    check("R6 random control", rd_data, model_read(rd_addr));
                default: check("R8 random map", rd_data, model_read(rd_addr));
            endcase
            check("R7 random irq", irq, m_flag & m_tie & m_gie);
        end
        wr_en = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule